// File: doc/BRIEF.md
# Memory-Type-Aware Store Buffer

This block sits between a processor's load/store request port and a single downstream memory request port. Every request carries a memory-type tag (Normal, Device or Strongly Ordered), a shared bit, and for Normal memory a cache policy. Writes to Normal and Device memory are posted into a small FIFO and drained to the downstream port in the background, one entry per cycle while the downstream side is ready. Reads, and all Strongly Ordered requests, are sent straight to the downstream port.

A direct request can only go once the entries it must not overtake have left the buffer. A Strongly Ordered request waits for an empty buffer. A Device read waits only for the buffered Device writes. A Normal read waits only for buffered writes to the same address. Until then the requester is stalled with its ready signal low. The block also marks each downstream request as cacheable or not, forces the shared attribute on Strongly Ordered traffic, and reports how many entries it holds. A barrier input makes it drain completely before it accepts anything.

Top module: `typed_store_buffer`

## Requirements
- R1: Memory type encoding is 2'b00 Normal, 2'b01 Device, 2'b10 Strongly Ordered, with 2'b11 handled as Strongly Ordered. Policy encoding is 2'b00 non-cacheable, 2'b01 write-through, 2'b10 write-back, with 2'b11 handled as non-cacheable. A Normal or Device write is taken into the buffer (`up_ready` high) in any cycle where fewer than DEPTH entries are held and no barrier is blocking.
- R2: Buffered entries leave in the order they were written, one per cycle in which `dn_ready` is high and no direct request uses the port. Each leaves with its address, data, strobes, type and `dn_write`=1.
- R3: A Device read is held (`up_ready` low) while any Device write is buffered. It is issued directly in the cycle after the last such write is accepted downstream, ahead of any Normal writes still buffered, and those Normal writes remain in the buffer.
- R4: A Strongly Ordered read or write is held while the buffer holds any entry. It is then issued directly and is never buffered. `up_ready` equals `dn_ready` in that cycle.
- R5: `dn_shared` is 1 for every Strongly Ordered request, whatever the shared input was. For other types it follows the request's shared bit.
- R6: `dn_cacheable` is 1 only for Normal requests that are not shared and whose policy is write-through or write-back. It is 0 in every other case.
- R7: A Normal read is held while any buffered entry has an address equal to the read address. Otherwise it is issued directly without waiting.
- R8: `fill_level` gives the number of buffered entries one cycle after each push or pop. With DEPTH entries held, buffered writes see `up_ready` low.
- R9: While `barrier_req` is high and the buffer is not empty, `up_ready` is low for every request and the buffer keeps draining. Once the buffer is empty, requests proceed normally.
- R10: After reset the buffer is empty (`fill_level`=0) and `dn_valid` is 0 until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_valid | input | 1 | Requester has an access pending |
| up_ready | output | 1 | Access accepted this cycle |
| up_write | input | 1 | 1 = write, 0 = read |
| up_addr | input | AW | Access address |
| up_wdata | input | DW | Write data |
| up_strb | input | DW/8 | Byte strobes |
| up_mtype | input | 2 | Memory type code |
| up_shared | input | 1 | Shared attribute |
| up_policy | input | 2 | Cache policy code for Normal memory |
| barrier_req | input | 1 | Level request for a full drain |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream accepts the request |
| dn_write | output | 1 | Downstream write flag |
| dn_addr | output | AW | Downstream address |
| dn_wdata | output | DW | Downstream write data |
| dn_strb | output | DW/8 | Downstream byte strobes |
| dn_mtype | output | 2 | Normalised memory type |
| dn_shared | output | 1 | Effective shared attribute |
| dn_cacheable | output | 1 | Request may be cached |
| fill_level | output | $clog2(DEPTH+1) | Number of buffered entries |

## Verification
`up_ready` and the downstream request are combinational in the current request and the buffer state, so they are due in the same cycle as the stimulus. `fill_level` changes one cycle after the push or pop handshake. A stalled direct request becomes ready in the cycle after the handshake of the last entry that blocks it. The bench drives inputs on the falling edge and evaluates its queue-based model 1 ns later. At that point it compares every output against the model. It then advances the model queue on the rising edge, so each expectation is taken in exactly the cycle its result is due.

// File: rtl/osb_pkg.sv
// Shared types for the memory-type-aware store buffer.
// Assumes 2-bit type and policy codes on the requester side; reserved codes
// are folded onto defined ones by the normalising helpers.
package osb_pkg;

    typedef enum logic [1:0] {
        MT_NORMAL = 2'b00,
        MT_DEVICE = 2'b01,
        MT_STRONG = 2'b10
    } mtype_e;

    typedef enum logic [1:0] {
        POL_NC = 2'b00,
        POL_WT = 2'b01,
        POL_WB = 2'b10
    } policy_e;

    typedef struct packed {
        mtype_e  mt;
        logic    shared;
        policy_e pol;
    } tag_t;

    // Fold the reserved type code onto Strongly Ordered.
    function automatic mtype_e norm_mtype(input logic [1:0] code);
        case (code)
            2'b00:   return MT_NORMAL;
            2'b01:   return MT_DEVICE;
            default: return MT_STRONG;
        endcase
    endfunction

    // Fold the reserved policy code onto non-cacheable.
    function automatic policy_e norm_policy(input logic [1:0] code);
        case (code)
            2'b01:   return POL_WT;
            2'b10:   return POL_WB;
            default: return POL_NC;
        endcase
    endfunction

endpackage

// File: rtl/osb_tag_norm.sv
// Turns raw requester attributes into a normalised tag and classifies the
// request as buffered (Normal or Device write) or direct (everything else).
// Purely combinational; assumes the inputs are stable while up_valid is high.
module osb_tag_norm
    import osb_pkg::*;
(
    input  logic       write,
    input  logic [1:0] mtype_raw,
    input  logic       shared_raw,
    input  logic [1:0] policy_raw,
    output tag_t       tag,
    output logic       buffered
);

    // Build the tag and decide which path the request takes.
    always_comb begin
        tag.mt     = norm_mtype(mtype_raw);
        tag.shared = shared_raw;
        tag.pol    = norm_policy(policy_raw);
        buffered   = write && (tag.mt != MT_STRONG);
    end

endmodule

// File: rtl/osb_attr_eval.sv
// Derives the downstream attributes from a normalised tag: the effective
// shared flag (Strongly Ordered is always shared) and whether the access
// may be cached (Normal, non-shared, write-through or write-back only).
module osb_attr_eval
    import osb_pkg::*;
(
    input  tag_t tag,
    output logic eff_shared,
    output logic cacheable
);

    // Evaluate shared and cacheable attributes.
    always_comb begin
        eff_shared = tag.shared || (tag.mt == MT_STRONG);
        cacheable  = (tag.mt == MT_NORMAL) && !tag.shared &&
                     ((tag.pol == POL_WT) || (tag.pol == POL_WB));
    end

endmodule

// File: rtl/osb_fifo.sv
// Ring-buffer storage for posted writes. Exposes the head entry for draining
// and a per-slot view (valid, address, tag) for the ordering checks.
// Assumes the caller never pushes when full nor pops when empty.
module osb_fifo
    import osb_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int SW   = DW / 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [AW-1:0]             push_addr,
    input  logic [DW-1:0]             push_data,
    input  logic [SW-1:0]             push_strb,
    input  tag_t                      push_tag,
    input  logic                      pop,
    output logic [AW-1:0]             head_addr,
    output logic [DW-1:0]             head_data,
    output logic [SW-1:0]             head_strb,
    output tag_t                      head_tag,
    output logic [DEPTH-1:0]          slot_valid,
    output logic [DEPTH-1:0][AW-1:0]  slot_addr,
    output tag_t [DEPTH-1:0]          slot_tag,
    output logic [LW-1:0]             level,
    output logic                      full,
    output logic                      empty
);

    logic [DEPTH-1:0][AW-1:0] mem_addr;
    logic [DEPTH-1:0][DW-1:0] mem_data;
    logic [DEPTH-1:0][SW-1:0] mem_strb;
    tag_t [DEPTH-1:0]         mem_tag;
    logic [DEPTH-1:0]         vld_q;
    logic [PW-1:0]            wr_ptr;
    logic [PW-1:0]            rd_ptr;
    logic [LW-1:0]            count;

    // Advance a slot pointer with wrap at DEPTH.
    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // Pointer, occupancy and valid-bit bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            vld_q  <= '0;
        end else begin
            if (push) begin
                vld_q[wr_ptr] <= 1'b1;
                wr_ptr        <= ptr_next(wr_ptr);
            end
            if (pop) begin
                vld_q[rd_ptr] <= 1'b0;
                rd_ptr        <= ptr_next(rd_ptr);
            end
            case ({push, pop})
                2'b10:   count <= count + LW'(1);
                2'b01:   count <= count - LW'(1);
                default: count <= count;
            endcase
        end
    end

    // Payload storage; contents are only meaningful where the valid bit is set.
    always_ff @(posedge clk) begin
        if (push) begin
            mem_addr[wr_ptr] <= push_addr;
            mem_data[wr_ptr] <= push_data;
            mem_strb[wr_ptr] <= push_strb;
            mem_tag[wr_ptr]  <= push_tag;
        end
    end

    // Present head entry, slot views and status.
    always_comb begin
        head_addr  = mem_addr[rd_ptr];
        head_data  = mem_data[rd_ptr];
        head_strb  = mem_strb[rd_ptr];
        head_tag   = mem_tag[rd_ptr];
        slot_valid = vld_q;
        slot_addr  = mem_addr;
        slot_tag   = mem_tag;
        level      = count;
        full       = (count == LW'(DEPTH));
        empty      = (count == '0);
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < LW'(DEPTH)));

    p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (vld_q != '0));

    p_level_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> $stable(count));

endmodule

// File: rtl/osb_hazard.sv
// Decides whether a direct request must wait for buffered entries:
// Strongly Ordered waits for an empty buffer, a Device read for no buffered
// Device write, a Normal read for no buffered write to the same address.
// Buffered-class requests never wait here.
module osb_hazard
    import osb_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DEPTH = 4
) (
    input  logic                     req_write,
    input  logic [AW-1:0]            req_addr,
    input  tag_t                     req_tag,
    input  logic [DEPTH-1:0]         slot_valid,
    input  logic [DEPTH-1:0][AW-1:0] slot_addr,
    input  tag_t [DEPTH-1:0]         slot_tag,
    output logic                     must_wait,
    output logic                     dev_pending
);

    logic any_valid;
    logic any_match;

    // Scan all slots for Device entries and address matches.
    always_comb begin
        any_valid   = |slot_valid;
        dev_pending = 1'b0;
        any_match   = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_valid[i]) begin
                if (slot_tag[i].mt == MT_DEVICE) dev_pending = 1'b1;
                if (slot_addr[i] == req_addr)    any_match   = 1'b1;
            end
        end
    end

    // Apply the ordering rule for the request's memory type.
    always_comb begin
        case (req_tag.mt)
            MT_STRONG: must_wait = any_valid;
            MT_DEVICE: must_wait = !req_write && dev_pending;
            default:   must_wait = !req_write && any_match;
        endcase
    end

endmodule

// File: rtl/typed_store_buffer.sv
// Memory-type-aware store buffer. Posts Normal and Device writes into a FIFO
// drained in order; sends reads and Strongly Ordered traffic directly once
// the entries they must not overtake have drained. A direct request that is
// clear to go takes the downstream port ahead of the buffer head.
// Assumes the requester holds its request stable until up_ready.
module typed_store_buffer
    import osb_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int SW   = DW / 8,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_valid,
    output logic          up_ready,
    input  logic          up_write,
    input  logic [AW-1:0] up_addr,
    input  logic [DW-1:0] up_wdata,
    input  logic [SW-1:0] up_strb,
    input  logic [1:0]    up_mtype,
    input  logic          up_shared,
    input  logic [1:0]    up_policy,
    input  logic          barrier_req,
    output logic          dn_valid,
    input  logic          dn_ready,
    output logic          dn_write,
    output logic [AW-1:0] dn_addr,
    output logic [DW-1:0] dn_wdata,
    output logic [SW-1:0] dn_strb,
    output logic [1:0]    dn_mtype,
    output logic          dn_shared,
    output logic          dn_cacheable,
    output logic [LW-1:0] fill_level
);

    tag_t                     req_tag;
    logic                     req_buffered;
    logic                     push;
    logic                     pop;
    logic [AW-1:0]            head_addr;
    logic [DW-1:0]            head_data;
    logic [SW-1:0]            head_strb;
    tag_t                     head_tag;
    logic [DEPTH-1:0]         slot_valid;
    logic [DEPTH-1:0][AW-1:0] slot_addr;
    tag_t [DEPTH-1:0]         slot_tag;
    logic                     fifo_full;
    logic                     fifo_empty;
    logic                     must_wait;
    logic                     dev_pending;
    logic                     barrier_block;
    logic                     direct_go;
    tag_t                     out_tag;

    osb_tag_norm i_norm (
        .write      (up_write),
        .mtype_raw  (up_mtype),
        .shared_raw (up_shared),
        .policy_raw (up_policy),
        .tag        (req_tag),
        .buffered   (req_buffered)
    );

    osb_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_addr  (up_addr),
        .push_data  (up_wdata),
        .push_strb  (up_strb),
        .push_tag   (req_tag),
        .pop        (pop),
        .head_addr  (head_addr),
        .head_data  (head_data),
        .head_strb  (head_strb),
        .head_tag   (head_tag),
        .slot_valid (slot_valid),
        .slot_addr  (slot_addr),
        .slot_tag   (slot_tag),
        .level      (fill_level),
        .full       (fifo_full),
        .empty      (fifo_empty)
    );

    osb_hazard #(.AW(AW), .DEPTH(DEPTH)) i_hazard (
        .req_write   (up_write),
        .req_addr    (up_addr),
        .req_tag     (req_tag),
        .slot_valid  (slot_valid),
        .slot_addr   (slot_addr),
        .slot_tag    (slot_tag),
        .must_wait   (must_wait),
        .dev_pending (dev_pending)
    );

    osb_attr_eval i_attr (
        .tag        (out_tag),
        .eff_shared (dn_shared),
        .cacheable  (dn_cacheable)
    );

    // Arbitration between the direct path and the buffer head, and the upstream handshake.
    always_comb begin
        barrier_block = barrier_req && !fifo_empty;
        direct_go     = up_valid && !req_buffered && !must_wait && !barrier_block;
        push          = up_valid && req_buffered && !fifo_full && !barrier_block;
        pop           = !direct_go && !fifo_empty && dn_ready;
        if (req_buffered) up_ready = !fifo_full && !barrier_block;
        else              up_ready = !must_wait && !barrier_block && dn_ready;
    end

    // Select the downstream payload.
    always_comb begin
        dn_valid = direct_go || !fifo_empty;
        if (direct_go) begin
            dn_write = up_write;
            dn_addr  = up_addr;
            dn_wdata = up_wdata;
            dn_strb  = up_strb;
            out_tag  = req_tag;
        end else begin
            dn_write = 1'b1;
            dn_addr  = head_addr;
            dn_wdata = head_data;
            dn_strb  = head_strb;
            out_tag  = head_tag;
        end
        dn_mtype = out_tag.mt;
    end

    p_strong_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_mtype == MT_STRONG) |-> (fill_level == '0));

    p_dev_read_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_write && dn_mtype == MT_DEVICE) |-> !dev_pending);

    p_barrier_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && barrier_req && fill_level != '0) |-> !up_ready);

    p_direct_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready && !req_buffered) |-> (dn_valid && dn_ready && dn_addr == up_addr));

    p_strong_shared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_mtype == MT_STRONG) |-> dn_shared);

    p_shared_uncached_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dn_cacheable |-> (dn_mtype == MT_NORMAL && !dn_shared));

    p_reset_empty_r10: assert property (@(posedge clk)
        !rst_n |=> (fill_level == '0));

endmodule

// File: tb/test_typed_store_buffer.sv
// Bench for typed_store_buffer: a queue-based reference model is evaluated
// every cycle and compared with all outputs.
module test_typed_store_buffer;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SW = 4;
    localparam int DEPTH = 4;
    localparam int LW = $clog2(DEPTH + 1);

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [SW-1:0] s;
        logic [1:0]    mt;
        logic          sh;
        logic [1:0]    pol;
    } ent_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          up_valid = 1'b0;
    logic          up_ready;
    logic          up_write = 1'b0;
    logic [AW-1:0] up_addr = '0;
    logic [DW-1:0] up_wdata = '0;
    logic [SW-1:0] up_strb = '0;
    logic [1:0]    up_mtype = '0;
    logic          up_shared = 1'b0;
    logic [1:0]    up_policy = '0;
    logic          barrier_req = 1'b0;
    logic          dn_valid;
    logic          dn_ready = 1'b0;
    logic          dn_write;
    logic [AW-1:0] dn_addr;
    logic [DW-1:0] dn_wdata;
    logic [SW-1:0] dn_strb;
    logic [1:0]    dn_mtype;
    logic          dn_shared;
    logic          dn_cacheable;
    logic [LW-1:0] fill_level;

    int   total = 0;
    int   bad = 0;
    ent_t q[$];
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #5 clk = ~clk;

    typed_store_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_typed_store_buffer (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid), .up_ready(up_ready), .up_write(up_write),
        .up_addr(up_addr), .up_wdata(up_wdata), .up_strb(up_strb),
        .up_mtype(up_mtype), .up_shared(up_shared), .up_policy(up_policy),
        .barrier_req(barrier_req),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
        .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_strb(dn_strb),
        .dn_mtype(dn_mtype), .dn_shared(dn_shared), .dn_cacheable(dn_cacheable),
        .fill_level(fill_level)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr;
    endfunction

    // One clock of the model: compare at mid-cycle, advance at the rising edge.
    task automatic step();
        ent_t  cur;
        ent_t  e;
        logic  empty, blk, is_buf, haz, exp_rdy, direct, pop, push, ew;
        string rt;
        #1;
        empty = (q.size() == 0);
        blk   = barrier_req && !empty;
        cur.a = up_addr; cur.d = up_wdata; cur.s = up_strb; cur.sh = up_shared;
        cur.mt  = (up_mtype == 2'b11) ? 2'b10 : up_mtype;           // R1 encoding
        cur.pol = (up_policy == 2'b11) ? 2'b00 : up_policy;         // R1 encoding
        is_buf = up_write && (cur.mt != 2'b10);
        haz = 1'b0;
        if (cur.mt == 2'b10) begin
            haz = !empty; rt = "R4";
        end else if (is_buf) begin
            rt = (q.size() < DEPTH) ? "R1" : "R8";
        end else if (cur.mt == 2'b01) begin
            foreach (q[i]) if (q[i].mt == 2'b01) haz = 1'b1;
            rt = "R3";
        end else begin
            foreach (q[i]) if (q[i].a == cur.a) haz = 1'b1;
            rt = "R7";
        end
        if (blk) rt = "R9";
        exp_rdy = is_buf ? ((q.size() < DEPTH) && !blk) : (!haz && !blk && dn_ready);
        direct  = up_valid && !is_buf && !haz && !blk;
        pop     = !direct && !empty && dn_ready;
        push    = up_valid && is_buf && (q.size() < DEPTH) && !blk;
        chk("R8", "fill_level", fill_level, q.size());
        if (up_valid) chk(rt, "up_ready", up_ready, exp_rdy);
        chk(direct ? rt : "R2", "dn_valid", dn_valid, direct || !empty);
        if (direct || !empty) begin
            e  = direct ? cur : q[0];
            ew = direct ? up_write : 1'b1;
            if (!direct) rt = "R2";
            chk(rt, "dn_write", dn_write, ew);
            chk(rt, "dn_addr", dn_addr, e.a);
            chk(rt, "dn_wdata", dn_wdata, e.d);
            chk(rt, "dn_strb", dn_strb, e.s);
            chk(rt, "dn_mtype", dn_mtype, e.mt);
            chk("R5", "dn_shared", dn_shared, e.sh || (e.mt == 2'b10));
            chk("R6", "dn_cacheable", dn_cacheable,
                (e.mt == 2'b00) && !e.sh && (e.pol == 2'b01 || e.pol == 2'b10));
        end
        @(posedge clk);
        if (pop) void'(q.pop_front());
        if (push) q.push_back(cur);
        @(negedge clk);
        if (up_valid && exp_rdy) up_valid = 1'b0;
    endtask

    task automatic put(input logic w, input logic [31:0] a, input logic [1:0] mt,
                       input logic sh, input logic [1:0] pol);
        up_valid = 1'b1; up_write = w; up_addr = a; up_wdata = a ^ 32'h5A5A_0000;
        up_strb = a[3:0] | 4'h1; up_mtype = mt; up_shared = sh; up_policy = pol;
    endtask

    task automatic finish_req(input bit random_ready);
        while (up_valid) begin
            if (random_ready) dn_ready = rnd() % 3 != 0;
            step();
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: empty and idle straight after reset
        chk("R10", "fill_level after reset", fill_level, 0);
        chk("R10", "dn_valid after reset", dn_valid, 0);
        @(negedge clk);

        // R1/R8: fill with dn_ready low, fifth write stalls, then FIFO drain (R2)
        dn_ready = 1'b0;
        put(1, 32'h10, 2'b00, 1, 2'b10); finish_req(0);
        put(1, 32'h14, 2'b00, 0, 2'b01); finish_req(0);
        put(1, 32'h18, 2'b00, 0, 2'b00); finish_req(0);
        put(1, 32'h1C, 2'b01, 0, 2'b00); finish_req(0);
        chk("R8", "level when full", fill_level, 4);
        put(1, 32'h20, 2'b00, 0, 2'b10);
        run(2);
        chk("R8", "write held while full", up_valid, 1);
        dn_ready = 1'b1;
        finish_req(0);
        run(6);
        chk("R2", "drained", fill_level, 0);

        // R3: Device read drains only Device writes; Normal writes remain
        dn_ready = 1'b0;
        put(1, 32'h100, 2'b00, 0, 2'b10); finish_req(0);
        put(1, 32'h200, 2'b01, 1, 2'b00); finish_req(0);
        put(1, 32'h300, 2'b00, 0, 2'b01); finish_req(0);
        put(1, 32'h400, 2'b00, 0, 2'b00); finish_req(0);
        put(0, 32'h500, 2'b01, 0, 2'b00);
        run(3);
        chk("R3", "device read held", up_valid, 1);
        dn_ready = 1'b1;
        finish_req(0);
        chk("R3", "normal writes left behind", fill_level, 2);
        run(3);

        // R4: Strongly Ordered write waits for empty buffer; reserved code 11 too (R1)
        dn_ready = 1'b0;
        put(1, 32'h600, 2'b00, 0, 2'b10); finish_req(0);
        put(1, 32'h604, 2'b01, 0, 2'b00); finish_req(0);
        put(1, 32'h608, 2'b11, 0, 2'b10);
        run(2);
        dn_ready = 1'b1;
        finish_req(0);
        chk("R4", "buffer empty after strong write", fill_level, 0);

        // R5: Strongly Ordered read with shared input low
        put(0, 32'h700, 2'b10, 0, 2'b00); finish_req(0);

        // R7: Normal read held by matching address, not by others
        dn_ready = 1'b0;
        put(1, 32'h800, 2'b00, 0, 2'b10); finish_req(0);
        put(0, 32'h804, 2'b00, 0, 2'b10);
        dn_ready = 1'b1;
        step();
        chk("R7", "non-matching read issued", up_valid, 0);
        dn_ready = 1'b0;
        put(1, 32'h808, 2'b00, 0, 2'b01); finish_req(0);
        put(0, 32'h808, 2'b00, 0, 2'b01);
        run(2);
        chk("R7", "matching read held", up_valid, 1);
        dn_ready = 1'b1;
        finish_req(0);
        run(3);

        // R9: barrier blocks everything until empty
        dn_ready = 1'b0;
        put(1, 32'h900, 2'b00, 0, 2'b00); finish_req(0);
        put(1, 32'h904, 2'b00, 0, 2'b00); finish_req(0);
        barrier_req = 1'b1;
        put(1, 32'h908, 2'b00, 0, 2'b00);
        run(2);
        chk("R9", "write held by barrier", up_valid, 1);
        dn_ready = 1'b1;
        finish_req(0);
        barrier_req = 1'b0;
        run(3);

        // Mixed traffic with random downstream readiness
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = rnd();
            barrier_req = (r[7:5] == 3'b000);
            put(r[0], 32'h40 + {28'd0, r[3:2], 2'b00}, r[9:8], r[10], r[12:11]);
            finish_req(1);
        end
        barrier_req = 1'b0;
        dn_ready = 1'b1;
        run(6);
        chk("R2", "final drain", fill_level, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule